// File: doc/BRIEF.md
# Pseudo-instruction macro expander

The block turns one assembler-level macro request into the short run of real 32-bit machine words that implements it. A request names a macro kind, a destination register, a source register and a 32-bit operand (a constant or a rotate amount). The block decides between the single-word and the multi-word form from the operand value, encodes every field, and emits the words one per cycle on an output stream with a last flag.

Multi-word forms that need a temporary value use register 1 as a scratch register, so the program must not keep live data there. Both edges are valid/ready streams. The input side accepts a request only when no expansion is outstanding, and holds `req_ready` low until the final word of the current expansion has been taken. The output side honours back-pressure: while `out_ready` is low, the presented word and its last flag hold still.

Top module: `macro_expander`

## Requirements
- R1: `req_ready` is high only while no expansion is outstanding. A request is taken on a cycle with `req_valid` and `req_ready` both high, and its first word is presented with `out_valid` high on the next cycle. `req_valid` has no effect while `req_ready` is low.
- R2: While `out_valid` is high and `out_ready` is low, `out_word` and `out_last` hold their values. Each accepted output beat advances the sequence by exactly one word.
- R3: `out_last` is high on the final word of each expansion and on no other word. In the cycle after that word is taken, `out_valid` is low and `req_ready` is high.
- R4: Kind codes are 0 no-op, 1 move, 2 load-immediate, 3 rotate-right and 4 add-unsigned-with-constant. Codes 5 to 7 act as no-op. A no-op emits the single word 0x00000000.
- R5: A move emits one add word of the form opcode[31:26]=0, rs[25:21]=0, rt[20:16]=source, rd[15:11]=destination, shamt[10:6]=0, funct[5:0]=0x20.
- R6: An operand fits when bits 31 to 15 are all equal. This means the operand equals the sign extension of its own low 16 bits.
- R7: A load-immediate whose operand fits emits one addi word: opcode 8, rs=0, rt=destination, bits 15:0 = operand low half.
- R8: A load-immediate whose operand does not fit emits two words. The first is lui (opcode 0x0F, rs=0, rt=destination, imm=upper half). The second is ori (opcode 0x0D, rs=rt=destination, imm=lower half).
- R9: A rotate-right by n (n taken modulo 32, n nonzero) emits three words in this order. First, srl with rd=1, rt=destination, shamt=n, funct 0x02. Second, sll with rd=rt=destination, shamt=32−n, funct 0x00. Third, or with rd=rs=destination, rt=1, funct 0x25.
- R10: The rotate amount is the operand modulo 32. An amount of 0 emits one add word with rd=rs=destination, rt=0, funct 0x20.
- R11: An add-unsigned-with-constant whose operand fits emits one addiu word: opcode 9, rs=source, rt=destination, imm=low half.
- R12: An add-unsigned-with-constant whose operand does not fit emits three words in this order. First, lui into register 1 with the upper half. Second, ori with rs=rt=1 and the lower half. Third, addu (funct 0x21) with rd=destination, rs=source, rt=1.
- R13: During and after reset, `out_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_kind | input | 3 | Macro kind code |
| req_dst | input | 5 | Destination register index |
| req_src | input | 5 | Source register index |
| req_operand | input | 32 | Constant or rotate amount |
| out_valid | output | 1 | Machine word presented |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Encoded machine word |
| out_last | output | 1 | Final word of the expansion |

## Verification
A step counter that skips or repeats a position shows up as a wrong or duplicated word on the very next output beat. A length decision taken on the wrong side of the fit boundary shows up as `out_last` arriving one or two words early or late. A latched request that changes mid-sequence corrupts a field of the next word. A hold failure under back-pressure changes `out_word` during a stalled cycle. A handshake fault either opens `req_ready` during an expansion or fails to raise `out_valid` in the cycle after acceptance. The table vectors sit on both sides of the 16-bit boundary and at the rotate amounts 0, 1 and 31, so each of these faults shows within one expansion.

// File: rtl/mx_pkg.sv
package mx_pkg;
  localparam int WORD_W  = 32;
  localparam int REG_W   = 5;
  localparam int IMM_W   = 16;
  localparam int KIND_W  = 3;
  localparam int STEP_W  = 2;

  localparam logic [KIND_W-1:0] K_NOP  = 3'd0;
  localparam logic [KIND_W-1:0] K_MOVE = 3'd1;
  localparam logic [KIND_W-1:0] K_LI   = 3'd2;
  localparam logic [KIND_W-1:0] K_ROR  = 3'd3;
  localparam logic [KIND_W-1:0] K_ADDK = 3'd4;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_ADDI    = 6'h08;
  localparam logic [5:0] OP_ADDIU   = 6'h09;
  localparam logic [5:0] OP_ORI     = 6'h0D;
  localparam logic [5:0] OP_LUI     = 6'h0F;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_OR   = 6'h25;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  src;
    logic [WORD_W-1:0] operand;
  } macro_req_t;

  function automatic logic [WORD_W-1:0] enc_r(
    input logic [REG_W-1:0] rs, input logic [REG_W-1:0] rt,
    input logic [REG_W-1:0] rd, input logic [4:0] sh, input logic [5:0] fn);
    return {OP_SPECIAL, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [WORD_W-1:0] enc_i(
    input logic [5:0] op, input logic [REG_W-1:0] rs,
    input logic [REG_W-1:0] rt, input logic [IMM_W-1:0] imm);
    return {op, rs, rt, imm};
  endfunction
endpackage

// File: rtl/mx_plan.sv
module mx_plan
  import mx_pkg::*;
(
  input  macro_req_t        req,
  output logic              fits,
  output logic [4:0]        amount,
  output logic [STEP_W-1:0] length
);
  localparam int HI_W = WORD_W - IMM_W + 1;

  logic [HI_W-1:0] upper;
  assign upper  = req.operand[WORD_W-1:IMM_W-1];
  assign fits   = (&upper) | ~(|upper);
  assign amount = req.operand[4:0];

  always_comb begin
    unique case (req.kind)
      K_LI:    length = fits ? 2'd1 : 2'd2;
      K_ROR:   length = (amount == 5'd0) ? 2'd1 : 2'd3;
      K_ADDK:  length = fits ? 2'd1 : 2'd3;
      default: length = 2'd1;
    endcase
  end
endmodule

// File: rtl/mx_encode.sv
module mx_encode
  import mx_pkg::*;
#(
  parameter logic [REG_W-1:0] SCRATCH = 5'd1
) (
  input  macro_req_t        req,
  input  logic              fits,
  input  logic [4:0]        amount,
  input  logic [STEP_W-1:0] step,
  output logic [WORD_W-1:0] word
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [IMM_W-1:0] lo_half, hi_half;
  logic [4:0]       back_amt;

  assign lo_half  = req.operand[IMM_W-1:0];
  assign hi_half  = req.operand[WORD_W-1:IMM_W];
  assign back_amt = 5'd0 - amount;

  always_comb begin
    word = '0;
    unique case (req.kind)
      K_MOVE: word = enc_r(ZERO_REG, req.src, req.dst, 5'd0, FN_ADD);
      K_LI: begin
        if (fits)              word = enc_i(OP_ADDI, ZERO_REG, req.dst, lo_half);
        else if (step == 2'd0) word = enc_i(OP_LUI, ZERO_REG, req.dst, hi_half);
        else                   word = enc_i(OP_ORI, req.dst, req.dst, lo_half);
      end
      K_ROR: begin
        if (amount == 5'd0)    word = enc_r(req.dst, ZERO_REG, req.dst, 5'd0, FN_ADD);
        else if (step == 2'd0) word = enc_r(ZERO_REG, req.dst, SCRATCH, amount, FN_SRL);
        else if (step == 2'd1) word = enc_r(ZERO_REG, req.dst, req.dst, back_amt, FN_SLL);
        else                   word = enc_r(req.dst, SCRATCH, req.dst, 5'd0, FN_OR);
      end
      K_ADDK: begin
        if (fits)              word = enc_i(OP_ADDIU, req.src, req.dst, lo_half);
        else if (step == 2'd0) word = enc_i(OP_LUI, ZERO_REG, SCRATCH, hi_half);
        else if (step == 2'd1) word = enc_i(OP_ORI, SCRATCH, SCRATCH, lo_half);
        else                   word = enc_r(req.src, SCRATCH, req.dst, 5'd0, FN_ADDU);
      end
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/macro_expander.sv
module macro_expander
  import mx_pkg::*;
#(
  parameter logic [REG_W-1:0] SCRATCH = 5'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [REG_W-1:0]  req_dst,
  input  logic [REG_W-1:0]  req_src,
  input  logic [WORD_W-1:0] req_operand,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last
);
  macro_req_t        held_q;
  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic              fits;
  logic [4:0]        amount;
  logic [STEP_W-1:0] length;
  logic              take_req, take_out;

  mx_plan u_plan (
    .req(held_q), .fits(fits), .amount(amount), .length(length)
  );

  mx_encode #(.SCRATCH(SCRATCH)) u_encode (
    .req(held_q), .fits(fits), .amount(amount), .step(step_q), .word(out_word)
  );

  assign req_ready = ~busy_q;
  assign out_valid = busy_q;
  assign out_last  = busy_q && (step_q == length - 2'd1);
  assign take_req  = req_valid && req_ready;
  assign take_out  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      held_q <= '0;
    end else if (take_req) begin
      busy_q <= 1'b1;
      step_q <= '0;
      held_q <= '{kind: req_kind, dst: req_dst, src: req_src, operand: req_operand};
    end else if (take_out) begin
      if (out_last) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else begin
        step_q <= step_q + 2'd1;
      end
    end
  end

  assert_accept_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> (out_valid && !req_ready));

  assert_hold_under_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));

  assert_drop_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_out && out_last) |=> (!out_valid && req_ready));

  assert_step_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (step_q < length));

  assert_nop_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (held_q.kind == K_NOP)) |-> (out_word == '0 && out_last));

  assert_rotate_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && held_q.kind == K_ROR && amount != 5'd0 && step_q == 2'd0) |-> !out_last);
endmodule

// File: tb/macro_expander_bench.sv
module macro_expander_bench;
  import mx_pkg::*;

  typedef struct packed {
    logic [2:0]  kind;
    logic [4:0]  dst;
    logic [4:0]  src;
    logic [31:0] val;
    logic [1:0]  len;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [31:0] w2;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 5'd7, 5'd3, 32'h1234_5678, 2'd1, 32'h0000_0000, 32'h0, 32'h0},
    '{3'd1, 5'd2, 5'd4, 32'h0000_0000, 2'd1, 32'h0004_1020, 32'h0, 32'h0},
    '{3'd2, 5'd8, 5'd0, 32'hFFFF_FFFF, 2'd1, 32'h2008_FFFF, 32'h0, 32'h0},
    '{3'd2, 5'd8, 5'd0, 32'h0000_7FFF, 2'd1, 32'h2008_7FFF, 32'h0, 32'h0},
    '{3'd2, 5'd8, 5'd0, 32'h0000_8000, 2'd2, 32'h3C08_0000, 32'h3508_8000, 32'h0},
    '{3'd2, 5'd9, 5'd0, 32'hABAB_CDCD, 2'd2, 32'h3C09_ABAB, 32'h3529_CDCD, 32'h0},
    '{3'd3, 5'd5, 5'd0, 32'h0000_0003, 2'd3, 32'h0005_08C2, 32'h0005_2F40, 32'h00A1_2825},
    '{3'd3, 5'd5, 5'd0, 32'h0000_0020, 2'd1, 32'h00A0_2820, 32'h0, 32'h0},
    '{3'd3, 5'd6, 5'd0, 32'h0000_0021, 2'd3, 32'h0006_0842, 32'h0006_37C0, 32'h00C1_3025},
    '{3'd4, 5'd4, 5'd5, 32'hFFFF_8000, 2'd1, 32'h24A4_8000, 32'h0, 32'h0},
    '{3'd4, 5'd4, 5'd5, 32'h1234_5678, 2'd3, 32'h3C01_1234, 32'h3421_5678, 32'h00A1_2021},
    '{3'd6, 5'd3, 5'd3, 32'hFFFF_FFFF, 2'd1, 32'h0000_0000, 32'h0, 32'h0},
    '{3'd3, 5'd5, 5'd0, 32'h0000_001F, 2'd3, 32'h0005_0FC2, 32'h0005_2840, 32'h00A1_2825}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [4:0]  req_dst = '0;
  logic [4:0]  req_src = '0;
  logic [31:0] req_operand = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        out_last;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  macro_expander u_macro_expander (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_dst(req_dst), .req_src(req_src),
    .req_operand(req_operand), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_last(out_last)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    case (v.kind)
      3'd1:    return "R5";
      3'd2:    return (v.len == 2'd1) ? "R7,R6" : "R8,R6";
      3'd3:    return (v.len == 2'd1) ? "R10" : "R9,R10";
      3'd4:    return (v.len == 2'd1) ? "R11,R6" : "R12,R6";
      default: return "R4";
    endcase
  endfunction

  task automatic offer(input vec_t v);
    req_kind = v.kind; req_dst = v.dst; req_src = v.src; req_operand = v.val;
    req_valid = 1'b1;
  endtask

  task automatic run_vec(input int idx);
    vec_t v;
    logic [31:0] exp_w, held;
    string tg;
    v  = VECS[idx];
    tg = tag_of(v);
    @(negedge clk);
    check(req_ready, "R1 ready idle", {31'd0, req_ready}, 32'd1);
    offer(v);
    @(negedge clk);
    req_valid = 1'b0;
    check(out_valid, "R1 first word next cycle", {31'd0, out_valid}, 32'd1);
    for (int k = 0; k < int'(v.len); k++) begin
      exp_w = (k == 0) ? v.w0 : (k == 1) ? v.w1 : v.w2;
      if (((idx + k) % 3) == 0) begin
        out_ready = 1'b0;
        held = out_word;
        @(negedge clk);
        check(out_valid && out_word == held, "R2 hold under stall", out_word, held);
        out_ready = 1'b1;
      end
      check(out_word == exp_w, tg, out_word, exp_w);
      check(out_last == (k == int'(v.len) - 1), "R3 last flag",
            {31'd0, out_last}, {31'd0, k == int'(v.len) - 1});
      check(!req_ready, "R1 ready low while busy", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
    end
    check(!out_valid && req_ready, "R3 idle after last",
          {30'd0, out_valid, req_ready}, 32'd1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    vec_t v;
    logic [31:0] exp_w;
    #1;
    // R13: outputs during reset
    repeat (2) @(negedge clk);
    check(!out_valid && req_ready, "R13 during reset",
          {30'd0, out_valid, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && req_ready, "R13 after reset",
          {30'd0, out_valid, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R1: a request offered while busy is ignored; sequence continues unchanged
    v = VECS[10];
    @(negedge clk);
    offer(v);
    @(negedge clk);
    req_kind = 3'd1; req_dst = 5'd31; req_src = 5'd31; req_operand = 32'hDEAD_BEEF;
    for (int k = 0; k < 3; k++) begin
      exp_w = (k == 0) ? v.w0 : (k == 1) ? v.w1 : v.w2;
      if (k == 2) req_valid = 1'b0;
      check(out_word == exp_w, "R1 busy ignores request", out_word, exp_w);
      @(negedge clk);
    end
    check(!out_valid, "R1 no extra accept", {31'd0, out_valid}, 32'd0);

    // R13: reset in the middle of a sequence
    offer(VECS[6]);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(!out_valid && req_ready, "R13 mid-sequence reset",
          {30'd0, out_valid, req_ready}, 32'd1);
    rst_n = 1'b1;
    run_vec(4);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule